// File: doc/BRIEF.md
# Metaframe Frame Lock Synchronizer

This block sits behind a word aligner that already delivers whole 67-bit words. It finds the boundaries of the metaframe within that word stream and tags every accepted word with its framing control type: data, synchronization, scrambler state, skip, diagnostic or unrecognised control. It keeps a frame lock flag for downstream logic, pulses a strobe on the first word of each locked metaframe, and publishes the scrambler state carried in the second word of each locked metaframe.

While unlocked, the block hunts word by word for a synchronization word. A run of correct synchronization words spaced one metaframe apart gives lock. While locked, it checks the first slot of each metaframe for a correct synchronization word and the second slot for a scrambler state word that matches its own prediction. Lock drops when either check fails too many times in a row, or at once when the upstream word aligner reports loss of alignment. The metaframe length and all three run counts are parameters.

Top module: `mframe_lock`

## Requirements
- R1: Each accepted word produces `tagValid`=1 and a `wordTag` one clock later. Bit 66 set means bits 63:0 arrive complemented and are restored first. Header bits 65:64 = 2'b01 gives tag 0 (data). Header 2'b10 marks a control word whose type sits in restored bits 63:58: type 6'h1E with bits 57:0 equal to the 58-bit pattern {2'b10, 56'h78F678F678F678} gives tag 1 (sync), type 6'h0A gives tag 2 (scrambler state), 6'h07 gives tag 3 (skip), 6'h19 gives tag 4 (diagnostic). Any other header or type, or a sync type with a wrong pattern, gives tag 5.
- R2: A word is accepted only when `wordValid` and `blkLock` are both high. A cycle without acceptance gives `tagValid`=0 and does not advance the metaframe position.
- R3: Frame lock is reached with the fourth sync word in a row, each found at metaframe position 0 (`META_LEN` accepted words after the previous one). `frameLock` rises in the same cycle as that word's tag.
- R4: While not locked, a non-sync word at the expected position 0 restarts the count, and the search resumes at the next sync word found anywhere.
- R5: While locked, a wrong word at position 0 counts as a bad sync. A correct sync clears the count. The fourth bad sync in a row drops `frameLock` together with that word's tag.
- R6: While locked, the word at position 1 must be a scrambler state word whose bits 57:0 equal the local prediction. The prediction is the last seeded state advanced 64 steps of the LFSR s' = {s[56:0], s[57]^s[38]} for each accepted word. The first scrambler state word after lock seeds the prediction and is not checked. A match clears the mismatch count. A mismatch or a different word type counts, and the third in a row drops `frameLock`.
- R7: While locked, every scrambler state word at position 1 puts its bits 57:0 on `scrState` together with its tag. `scrState` holds between such words.
- R8: `metaStart` is 1 with the tag of each position-0 word after which the block is locked, including the word that gains lock. It is 1 at no other time.
- R9: `blkLock` low clears `frameLock` at the next clock and restarts the search.
- R10: After reset, `frameLock`, `tagValid`, `metaStart` and `scrState` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blkLock | input | 1 | Upstream word alignment is valid |
| wordValid | input | 1 | `wordData` carries a word this cycle |
| wordData | input | 67 | Aligned word: inversion flag, header, payload |
| frameLock | output | 1 | Metaframe lock status |
| tagValid | output | 1 | `wordTag` is valid this cycle |
| wordTag | output | 3 | Framing type of the last accepted word |
| metaStart | output | 1 | First word of a locked metaframe |
| scrState | output | 58 | Scrambler state from the last checked state word |

## Verification
A position counter that is off by one shows up within one metaframe. Under lock, the sync slot falls on a data word and `metaStart` lands on the wrong tag, and lock is lost four metaframes later. A wrong scrambler prediction, such as one that also advances on idle cycles, makes `frameLock` fall on the third checked state word even though the stream is clean. A miscounted run threshold moves the cycle in which `frameLock` rises or falls by exactly one metaframe, so every lock and loss transition is sampled in the cycle of the word that causes it.

// File: rtl/mfl_pkg.sv
package mfl_pkg;
  localparam int WORD_W = 67;
  localparam int PAY_W  = 64;
  localparam int SCR_W  = 58;
  localparam int TYPE_W = 6;

  typedef enum logic [2:0] {
    TAG_DATA  = 3'd0,
    TAG_SYNC  = 3'd1,
    TAG_SCRST = 3'd2,
    TAG_SKIP  = 3'd3,
    TAG_DIAG  = 3'd4,
    TAG_OTHER = 3'd5
  } wordTag_e;

  localparam logic [TYPE_W-1:0] TYPE_SYNC  = 6'h1E;
  localparam logic [TYPE_W-1:0] TYPE_SCRST = 6'h0A;
  localparam logic [TYPE_W-1:0] TYPE_SKIP  = 6'h07;
  localparam logic [TYPE_W-1:0] TYPE_DIAG  = 6'h19;
  localparam logic [SCR_W-1:0]  SYNC_PAT   = {2'b10, 56'h78F678F678F678};

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic align;       // this word is metaframe position 0
    logic seedScr;     // load prediction from received state
    logic clearSeed;   // forget the prediction
    logic captureScr;  // publish received state
    logic metaStart;   // flag metaframe start with this tag
  } ctrlStrobe_t;

  // 64 steps of the x^58 + x^39 + 1 LFSR, one word's worth
  function automatic logic [SCR_W-1:0] scrAdvance(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0] v;
    v = s;
    for (int i = 0; i < PAY_W; i++) begin
      v = {v[SCR_W-2:0], v[SCR_W-1] ^ v[38]};
    end
    return v;
  endfunction
endpackage

// File: rtl/mfl_datapath.sv
module mfl_datapath
  import mfl_pkg::*;
#(
  parameter int META_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic [WORD_W-1:0] wordData,
  input  ctrlStrobe_t       strobe,
  input  logic              frameLock,
  output logic              isSync,
  output logic              isScr,
  output logic              scrMatch,
  output logic              seeded,
  output logic              posZero,
  output logic              posOne,
  output logic              tagValid,
  output logic [2:0]        wordTag,
  output logic              metaStart,
  output logic [SCR_W-1:0]  scrState
);
  localparam int PW = (META_LEN > 2) ? $clog2(META_LEN) : 2;
  localparam logic [PW-1:0] POS_LAST = PW'(META_LEN - 1);

  logic [PAY_W-1:0]  payload;
  logic [1:0]        hdr;
  logic [TYPE_W-1:0] typeF;
  logic [SCR_W-1:0]  body;
  wordTag_e          tagNow;
  logic [PW-1:0]     pos;
  logic [SCR_W-1:0]  localScr;

  // Undo the inversion, then classify
  always_comb begin
    payload = wordData[WORD_W-1] ? ~wordData[PAY_W-1:0] : wordData[PAY_W-1:0];
    hdr     = wordData[PAY_W+1:PAY_W];
    typeF   = payload[PAY_W-1:SCR_W];
    body    = payload[SCR_W-1:0];
    tagNow  = TAG_OTHER;
    if (hdr == 2'b01) begin
      tagNow = TAG_DATA;
    end else if (hdr == 2'b10) begin
      unique case (typeF)
        TYPE_SYNC:  tagNow = (body == SYNC_PAT) ? TAG_SYNC : TAG_OTHER;
        TYPE_SCRST: tagNow = TAG_SCRST;
        TYPE_SKIP:  tagNow = TAG_SKIP;
        TYPE_DIAG:  tagNow = TAG_DIAG;
        default:    tagNow = TAG_OTHER;
      endcase
    end
  end

  assign isSync   = (tagNow == TAG_SYNC);
  assign isScr    = (tagNow == TAG_SCRST);
  assign scrMatch = (body == localScr);
  assign posZero  = (pos == '0);
  assign posOne   = (pos == PW'(1));

  // Metaframe position of the incoming word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= '0;
    end else if (accept) begin
      if (strobe.align)        pos <= PW'(1);
      else if (pos == POS_LAST) pos <= '0;
      else                     pos <= pos + PW'(1);
    end
  end

  // Local scrambler prediction for the incoming word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      localScr <= '0;
      seeded   <= 1'b0;
    end else begin
      if (accept) begin
        localScr <= strobe.seedScr ? scrAdvance(body) : scrAdvance(localScr);
      end
      if (strobe.clearSeed)                seeded <= 1'b0;
      else if (accept && strobe.seedScr)   seeded <= 1'b1;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagValid  <= 1'b0;
      wordTag   <= TAG_DATA;
      metaStart <= 1'b0;
      scrState  <= '0;
    end else begin
      tagValid  <= accept;
      metaStart <= accept && strobe.metaStart;
      if (accept) wordTag <= tagNow;
      if (accept && strobe.captureScr) scrState <= body;
    end
  end

  AST_NO_TAG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !tagValid) else $error("tag without accepted word"); // R2
  AST_META_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    metaStart |-> frameLock) else $error("metaStart while unlocked"); // R8
  AST_SCR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && strobe.captureScr) |=> $stable(scrState)) else $error("scrState moved"); // R7
endmodule

// File: rtl/mfl_control.sv
module mfl_control
  import mfl_pkg::*;
#(
  parameter int LOCK_SYNCS = 4,
  parameter int SYNC_ERRS  = 4,
  parameter int SCR_ERRS   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkLock,
  input  logic        accept,
  input  logic        isSync,
  input  logic        isScr,
  input  logic        scrMatch,
  input  logic        seeded,
  input  logic        posZero,
  input  logic        posOne,
  output ctrlStrobe_t strobe,
  output logic        frameLock
);
  localparam int GW = $clog2(LOCK_SYNCS + 1);
  localparam int BW = $clog2(SYNC_ERRS + 1);
  localparam int EW = $clog2(SCR_ERRS + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCKED} state_e;

  state_e        state, stateNxt;
  logic [GW-1:0] goodCnt, goodNxt;
  logic [BW-1:0] badCnt, badNxt;
  logic [EW-1:0] scrErrCnt, scrErrNxt;
  logic          loseLock;

  always_comb begin
    stateNxt  = state;
    goodNxt   = goodCnt;
    badNxt    = badCnt;
    scrErrNxt = scrErrCnt;
    strobe    = '0;
    loseLock  = 1'b0;
    if (!blkLock) begin
      loseLock = 1'b1;
    end else if (accept) begin
      unique case (state)
        ST_HUNT: begin
          if (isSync) begin
            strobe.align = 1'b1;
            if (LOCK_SYNCS <= 1) begin
              stateNxt         = ST_LOCKED;
              strobe.metaStart = 1'b1;
            end else begin
              stateNxt = ST_VERIFY;
              goodNxt  = GW'(1);
            end
          end
        end
        ST_VERIFY: begin
          if (posZero) begin
            if (!isSync) begin
              stateNxt = ST_HUNT;
              goodNxt  = '0;
            end else if (goodCnt == GW'(LOCK_SYNCS - 1)) begin
              stateNxt         = ST_LOCKED;
              goodNxt          = '0;
              strobe.metaStart = 1'b1;
            end else begin
              goodNxt = goodCnt + GW'(1);
            end
          end
        end
        default: begin
          if (posZero) begin
            if (isSync) begin
              badNxt           = '0;
              strobe.metaStart = 1'b1;
            end else if (badCnt == BW'(SYNC_ERRS - 1)) begin
              loseLock = 1'b1;
            end else begin
              badNxt           = badCnt + BW'(1);
              strobe.metaStart = 1'b1;
            end
          end else if (posOne) begin
            if (isScr) strobe.captureScr = 1'b1;
            if (isScr && !seeded) begin
              strobe.seedScr = 1'b1;
            end else if (isScr && scrMatch) begin
              scrErrNxt = '0;
            end else if (scrErrCnt == EW'(SCR_ERRS - 1)) begin
              loseLock = 1'b1;
            end else begin
              scrErrNxt = scrErrCnt + EW'(1);
            end
          end
        end
      endcase
    end
    if (loseLock) begin
      stateNxt         = ST_HUNT;
      goodNxt          = '0;
      badNxt           = '0;
      scrErrNxt        = '0;
      strobe.clearSeed = 1'b1;
      strobe.metaStart = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      goodCnt   <= '0;
      badCnt    <= '0;
      scrErrCnt <= '0;
    end else begin
      state     <= stateNxt;
      goodCnt   <= goodNxt;
      badCnt    <= badNxt;
      scrErrCnt <= scrErrNxt;
    end
  end

  assign frameLock = (state == ST_LOCKED);

  AST_BLK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !blkLock |=> !frameLock) else $error("lock kept without block lock"); // R9
  AST_LOCK_ON_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameLock) |-> $past(accept && isSync && blkLock)) else $error("lock without sync"); // R3
  AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameLock) |-> $past(!blkLock || (accept && (posZero || posOne)))) else $error("lock lost off slot"); // R5, R6
endmodule

// File: rtl/mframe_lock.sv
module mframe_lock
  import mfl_pkg::*;
#(
  parameter int META_LEN   = 8,
  parameter int LOCK_SYNCS = 4,
  parameter int SYNC_ERRS  = 4,
  parameter int SCR_ERRS   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkLock,
  input  logic        wordValid,
  input  logic [66:0] wordData,
  output logic        frameLock,
  output logic        tagValid,
  output logic [2:0]  wordTag,
  output logic        metaStart,
  output logic [57:0] scrState
);
  logic        accept;
  logic        isSync, isScr, scrMatch, seeded, posZero, posOne;
  ctrlStrobe_t strobe;

  assign accept = blkLock && wordValid;

  mfl_datapath #(.META_LEN(META_LEN)) u_datapath (
    .clk(clk), .rstN(rstN), .accept(accept), .wordData(wordData),
    .strobe(strobe), .frameLock(frameLock),
    .isSync(isSync), .isScr(isScr), .scrMatch(scrMatch), .seeded(seeded),
    .posZero(posZero), .posOne(posOne),
    .tagValid(tagValid), .wordTag(wordTag), .metaStart(metaStart), .scrState(scrState)
  );

  mfl_control #(.LOCK_SYNCS(LOCK_SYNCS), .SYNC_ERRS(SYNC_ERRS), .SCR_ERRS(SCR_ERRS)) u_control (
    .clk(clk), .rstN(rstN), .blkLock(blkLock), .accept(accept),
    .isSync(isSync), .isScr(isScr), .scrMatch(scrMatch), .seeded(seeded),
    .posZero(posZero), .posOne(posOne), .strobe(strobe), .frameLock(frameLock)
  );
endmodule

// File: tb/mframe_lock_bench.sv
`timescale 1ns/1ps
module mframe_lock_bench;
  import mfl_pkg::*;

  localparam int LEN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blkLock = 1'b0;
  logic        wordValid = 1'b0;
  logic [66:0] wordData = '0;
  logic        frameLock, tagValid, metaStart;
  logic [2:0]  wordTag;
  logic [57:0] scrState;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [57:0] curScr = 58'h3_2345_6789_ABCD;
  logic        lock0, lock1, ms0, ms1;
  logic [57:0] scr1, usedScr;

  always #10 clk = ~clk;

  mframe_lock u_mframe_lock (
    .clk(clk), .rstN(rstN), .blkLock(blkLock), .wordValid(wordValid), .wordData(wordData),
    .frameLock(frameLock), .tagValid(tagValid), .wordTag(wordTag),
    .metaStart(metaStart), .scrState(scrState)
  );

  // Entry: {inv, hdr[1:0], type[5:0], patOk, expTag[2:0]}
  localparam logic [12:0] TAGVEC [9] = '{
    {1'b0, 2'b01, 6'h00, 1'b0, 3'd0},
    {1'b0, 2'b10, 6'h1E, 1'b1, 3'd1},
    {1'b0, 2'b10, 6'h1E, 1'b0, 3'd5},
    {1'b0, 2'b10, 6'h0A, 1'b0, 3'd2},
    {1'b0, 2'b10, 6'h07, 1'b0, 3'd3},
    {1'b1, 2'b10, 6'h19, 1'b0, 3'd4},
    {1'b1, 2'b10, 6'h1E, 1'b1, 3'd1},
    {1'b0, 2'b11, 6'h07, 1'b0, 3'd5},
    {1'b0, 2'b00, 6'h1E, 1'b1, 3'd5}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [57:0] lfsrWord(input logic [57:0] s);
    logic [57:0] v = s;
    for (int i = 0; i < 64; i++) v = {v[56:0], v[57] ^ v[38]};
    return v;
  endfunction

  function automatic logic [66:0] mkCtl(input logic [5:0] t, input logic [57:0] b,
                                        input logic inv, input logic [1:0] hdr);
    logic [63:0] p = {t, b};
    return {inv, hdr, inv ? ~p : p};
  endfunction

  function automatic logic [66:0] mkData(input int n);
    return {1'b0, 2'b01, 64'(n) * 64'h9E37_79B9_7F4A_7C15};
  endfunction

  // Called at a negedge; returns at the next negedge with outputs for w
  task automatic sendWord(input logic [66:0] w);
    wordData  = w;
    wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic idle(input int n);
    wordValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic goodSync, input logic goodScr, input logic gap);
    sendWord(goodSync ? mkCtl(TYPE_SYNC, SYNC_PAT, 1'b0, 2'b10) : mkData(7));
    lock0 = frameLock; ms0 = metaStart;
    usedScr = curScr;
    sendWord(mkCtl(TYPE_SCRST, goodScr ? curScr : curScr ^ 58'h1, 1'b0, 2'b10));
    lock1 = frameLock; ms1 = metaStart; scr1 = scrState;
    for (int i = 2; i < LEN; i++) begin
      sendWord(mkData(i));
      if (gap && i == 2) idle(2);
    end
    for (int i = 0; i < LEN; i++) curScr = lfsrWord(curScr);
  endtask

  task automatic relink();
    blkLock = 1'b0;
    idle(1);
    blkLock = 1'b1;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "frameLock", 64'(frameLock), 0);
    check("R10", "tagValid", 64'(tagValid), 0);
    check("R10", "metaStart", 64'(metaStart), 0);
    check("R10", "scrState", 64'(scrState), 0);
    rstN = 1'b1;
    blkLock = 1'b1;
    @(negedge clk);

    // R1 classification table
    foreach (TAGVEC[k]) begin
      sendWord(mkCtl(TAGVEC[k][9:4], TAGVEC[k][3] ? SYNC_PAT : 58'h155,
                     TAGVEC[k][12], TAGVEC[k][11:10]));
      check("R1", "tagValid", 64'(tagValid), 1);
      check("R1", "wordTag", 64'(wordTag), 64'(TAGVEC[k][2:0]));
    end

    // R2 no acceptance without block lock or valid
    blkLock = 1'b0;
    sendWord(mkCtl(TYPE_SYNC, SYNC_PAT, 1'b0, 2'b10));
    check("R2", "tagValid blkLock low", 64'(tagValid), 0);
    blkLock = 1'b1;
    idle(1);
    check("R2", "tagValid valid low", 64'(tagValid), 0);

    // R3 lock on fourth sync; R8 metaStart; gaps show no position advance (R2)
    for (int f = 0; f < 3; f++) begin
      sendFrame(1'b1, 1'b1, f == 1);
      check("R3", "unlocked before fourth sync", 64'(lock0), 0);
      check("R8", "no metaStart unlocked", 64'(ms0), 0);
    end
    sendFrame(1'b1, 1'b1, 1'b1);
    check("R3", "lock on fourth sync", 64'(lock0), 1);
    check("R8", "metaStart on locking word", 64'(ms0), 1);
    check("R8", "no metaStart at position 1", 64'(ms1), 0);
    check("R7", "scrState seeded word", 64'(scr1), 64'(usedScr));
    sendFrame(1'b1, 1'b1, 1'b1);
    check("R2", "lock kept across gaps", 64'(lock1), 1);
    check("R7", "scrState next metaframe", 64'(scr1), 64'(usedScr));
    check("R6", "matching state keeps lock", 64'(lock1), 1);

    // R4 a miss restarts the count
    relink();
    sendFrame(1'b1, 1'b1, 1'b0);
    sendFrame(1'b1, 1'b1, 1'b0);
    sendFrame(1'b0, 1'b1, 1'b0);
    for (int f = 0; f < 3; f++) sendFrame(1'b1, 1'b1, 1'b0);
    check("R4", "count restarted after miss", 64'(lock0), 0);
    sendFrame(1'b1, 1'b1, 1'b0);
    check("R4", "lock after fresh four", 64'(lock0), 1);

    // R5 bad sync run
    for (int f = 0; f < 3; f++) sendFrame(1'b0, 1'b1, 1'b0);
    check("R5", "three bad syncs keep lock", 64'(lock1), 1);
    check("R8", "metaStart on bad sync slot", 64'(ms0), 1);
    sendFrame(1'b1, 1'b1, 1'b0);
    for (int f = 0; f < 3; f++) sendFrame(1'b0, 1'b1, 1'b0);
    check("R5", "count cleared by good sync", 64'(lock1), 1);
    sendFrame(1'b0, 1'b1, 1'b0);
    check("R5", "fourth bad sync drops lock", 64'(lock0), 0);
    check("R8", "no metaStart on loss", 64'(ms0), 0);

    // R6 scrambler mismatch run
    for (int f = 0; f < 4; f++) sendFrame(1'b1, 1'b1, 1'b0);
    check("R6", "relocked", 64'(lock0), 1);
    sendFrame(1'b1, 1'b1, 1'b0);
    sendFrame(1'b1, 1'b0, 1'b0);
    sendFrame(1'b1, 1'b0, 1'b0);
    sendFrame(1'b1, 1'b1, 1'b0);
    check("R6", "match clears mismatch count", 64'(lock1), 1);
    sendFrame(1'b1, 1'b0, 1'b0);
    sendFrame(1'b1, 1'b0, 1'b0);
    check("R6", "two mismatches keep lock", 64'(lock1), 1);
    sendFrame(1'b1, 1'b0, 1'b0);
    check("R6", "third mismatch drops lock", 64'(lock1), 0);

    // R9 block lock loss
    for (int f = 0; f < 4; f++) sendFrame(1'b1, 1'b1, 1'b0);
    check("R9", "locked before drop", 64'(frameLock), 1);
    blkLock = 1'b0;
    idle(1);
    check("R9", "lock cleared by blkLock", 64'(frameLock), 0);
    blkLock = 1'b1;
    sendFrame(1'b1, 1'b1, 1'b0);
    check("R9", "search restarted", 64'(lock0), 0);

    finishRun();
  end
endmodule